// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block merges three reset requests into one stretched reset. The requests are a power-good flag from an external comparator, a debounced manual-reset request and a single-cycle watchdog expiry strobe. A loss of power-good drives reset through a purely combinational path, so no clock edge lies on that path. Manual and watchdog requests are taken on the next clock edge.

After the last request goes away, reset stays asserted while a counter collects a fixed number of 1 ms tick enables (`HOLD_TICKS`, default 610, legal range 250 to 1000, checked at elaboration). Reset is then released. Any fresh request during the hold clears the count. Reset is also asserted from the moment the logic's own asynchronous reset is applied, so power-up gets the same stretched pulse. The active-high output, the active-low output and the `resetActive` flag for the watchdog all move together.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rstN` is low, and after it rises, `resetHi` is 1. Power-up counts as a request that clears at the `rstN` release.
- R2: Reset is released on the clock edge that counts the `HOLD_TICKS`-th tick since the last request was removed. A tick counts only on an edge where `tickEn` is 1 and no request is present. Reset is not released earlier.
- R3: When `pwrGood` is 0, `resetHi` is 1 immediately, with no clock edge needed.
- R4: When `pwrGood` returns to 1, reset is held for `HOLD_TICKS` ticks and then released.
- R5: When `manualReq` is 1, `resetHi` is 1 after the next clock edge. Reset is held for `HOLD_TICKS` ticks after `manualReq` returns to 0.
- R6: A one-cycle `wdogExpire` pulse gives a reset that is 1 after the next edge and lasts `HOLD_TICKS` ticks.
- R7: A request that arrives during the hold restarts the count from zero.
- R8: Ticks that arrive while a request is present are not counted.
- R9: `resetLo` is always the inverse of `resetHi`, and `resetActive` always equals `resetHi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of the logic |
| tickEn | input | 1 | One-cycle 1 ms time-base enable |
| pwrGood | input | 1 | Supply within tolerance (1 = good) |
| manualReq | input | 1 | Debounced manual reset request, active high |
| wdogExpire | input | 1 | Watchdog time-out strobe, active high |
| resetHi | output | 1 | Reset, active high |
| resetLo | output | 1 | Reset, active low |
| resetActive | output | 1 | Reset asserted, used to hold the watchdog cleared |

## Verification
Four properties are checked on every cycle:
- a low power-good always shows reset;
- manual and watchdog requests show reset one edge later;
- reset is released only on an edge that has a counted tick and no pending request;
- while reset is low, a reference count of quiet ticks sits exactly at the hold length.

The bench scenarios are needed for the rest:
- the exact tick count at release for several tick spacings;
- the restart of the count by a request in the middle of a hold;
- the zero-time response of the power path between clock edges;
- the power-up pulse.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // strobes from the control FSM to the hold counter datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } holdStrobe_t;
endpackage

// File: rtl/supv_hold_dp.sv
module supv_hold_dp
  import supv_pkg::*;
#(
  parameter int HOLD_TICKS = 610
) (
  input  logic        clk,
  input  logic        rstN,
  input  holdStrobe_t strobe,
  output logic        holdDone
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.clrCnt) begin
      holdCnt <= '0;
    end else if (strobe.incCnt) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // true when the next counted tick completes the hold window
  assign holdDone = (holdCnt == LAST_CNT);
endmodule

// File: rtl/supv_hold_ctl.sv
module supv_hold_ctl
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqAny,
  input  logic        tickEn,
  input  logic        holdDone,
  output holdStrobe_t strobe,
  output logic        holding
);
  logic finishHold;

  assign finishHold = holding && tickEn && holdDone && !reqAny;

  always_comb begin
    strobe.clrCnt = reqAny || finishHold;
    strobe.incCnt = holding && tickEn && !reqAny && !holdDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holding <= 1'b1;
    end else if (reqAny) begin
      holding <= 1'b1;
    end else if (finishHold) begin
      holding <= 1'b0;
    end
  end
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int HOLD_TICKS = 610
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic pwrGood,
  input  logic manualReq,
  input  logic wdogExpire,
  output logic resetHi,
  output logic resetLo,
  output logic resetActive
);
  if (HOLD_TICKS < 250 || HOLD_TICKS > 1000) begin : gBadHold
    $error("HOLD_TICKS out of range 250..1000");
  end

  holdStrobe_t strobe;
  logic        holdDone;
  logic        holding;
  logic        reqAny;

  assign reqAny = !pwrGood || manualReq || wdogExpire;

  supv_hold_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .reqAny  (reqAny),
    .tickEn  (tickEn),
    .holdDone(holdDone),
    .strobe  (strobe),
    .holding (holding)
  );

  supv_hold_dp #(.HOLD_TICKS(HOLD_TICKS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .holdDone(holdDone)
  );

  // power failure bypasses every register
  assign resetHi     = holding || !pwrGood;
  assign resetLo     = !resetHi;
  assign resetActive = resetHi;
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int HOLD_TICKS = 610
) (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic pwrGood,
  input logic manualReq,
  input logic wdogExpire,
  input logic resetHi
);
  localparam int Q_W = $clog2(HOLD_TICKS + 1) + 1;

  logic         reqSeen;
  logic [Q_W-1:0] quietTicks;

  assign reqSeen = !pwrGood || manualReq || wdogExpire;

  // reference count of ticks since the last request, saturating at the hold length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietTicks <= '0;
    end else if (reqSeen) begin
      quietTicks <= '0;
    end else if (tickEn && (quietTicks < Q_W'(HOLD_TICKS))) begin
      quietTicks <= quietTicks + 1'b1;
    end
  end

  // R3
  pwr_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |-> resetHi);

  // R5 R6
  req_assert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (manualReq || wdogExpire) |=> resetHi);

  // R2 R8
  release_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetHi) |-> ($past(tickEn) && $past(pwrGood) && !$past(manualReq) && !$past(wdogExpire)));

  // R2 R7
  hold_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resetHi |-> (quietTicks == Q_W'(HOLD_TICKS)));
endmodule

bind supv_reset_gen supv_reset_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .pwrGood   (pwrGood),
  .manualReq (manualReq),
  .wdogExpire(wdogExpire),
  .resetHi   (resetHi)
);

// File: tb/supv_reset_gen_tb.sv
module supv_reset_gen_tb;
  localparam int HOLD = 250;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic pwrGood = 1'b0;
  logic manualReq = 1'b0;
  logic wdogExpire = 1'b0;
  logic resetHi, resetLo, resetActive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  supv_reset_gen #(.HOLD_TICKS(HOLD)) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .pwrGood    (pwrGood),
    .manualReq  (manualReq),
    .wdogExpire (wdogExpire),
    .resetHi    (resetHi),
    .resetLo    (resetLo),
    .resetActive(resetActive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOut(input string req, input bit expHi);
    check(resetHi == expHi, req, resetHi, expHi);
    check(resetLo == !expHi, "R9 resetLo", resetLo, !expHi);
    check(resetActive == expHi, "R9 resetActive", resetActive, expHi);
  endtask

  // called just after a negedge with no request present and tickEn low
  task automatic waitRelease(input int tp, input string req);
    int ticks = 0;
    int cyc = 0;
    bit released = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!resetHi) begin
        released = 1'b1;
        break;
      end
      tickEn = ((cyc % tp) == tp - 1);
      cyc++;
      if (tickEn) ticks++;
    end
    tickEn = 1'b0;
    check(released, req, released, 1);
    check(ticks == HOLD, req, ticks, HOLD);
    checkOut("R9 released", 1'b0);
  endtask

  task automatic runTicks(input int n, input bit expHi, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (resetHi !== expHi) ok = 1'b0;
      tickEn = 1'b1;
    end
    @(negedge clk);
    if (resetHi !== expHi) ok = 1'b0;
    tickEn = 1'b0;
    check(ok, req, ok, 1);
  endtask

  initial begin
    #1;
    // R1 R3: logic reset with power low
    checkOut("R1 R3 time zero", 1'b1);
    repeat (3) @(negedge clk);
    pwrGood = 1'b1;
    #1;
    checkOut("R1 in reset", 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after rstN", 1'b1);
    // R1 R2: power-up pulse, tick every cycle
    waitRelease(1, "R2 power-up hold");
    runTicks(20, 1'b0, "R2 stays released");

    // R3 R4: power fail between edges, then return with sparse ticks
    #1 pwrGood = 1'b0;
    #1;
    checkOut("R3 combinational assert", 1'b1);
    @(negedge clk);
    runTicks(10, 1'b1, "R8 ticks during power fail");
    pwrGood = 1'b1;
    waitRelease(3, "R4 power return hold");

    // R5 R8: manual request with ticks during it
    @(negedge clk);
    manualReq = 1'b1;
    #1;
    checkOut("R5 no edge yet", 1'b0);
    @(negedge clk);
    checkOut("R5 asserted next edge", 1'b1);
    runTicks(300, 1'b1, "R8 manual held with ticks");
    manualReq = 1'b1;
    @(negedge clk);
    manualReq = 1'b0;
    waitRelease(7, "R5 manual hold");

    // R6: single-cycle watchdog expiry
    @(negedge clk);
    wdogExpire = 1'b1;
    @(negedge clk);
    wdogExpire = 1'b0;
    checkOut("R6 watchdog asserted", 1'b1);
    waitRelease(2, "R6 watchdog pulse length");

    // R7: second expiry in the middle of the hold restarts the count
    @(negedge clk);
    wdogExpire = 1'b1;
    @(negedge clk);
    wdogExpire = 1'b0;
    runTicks(HOLD - 10, 1'b1, "R7 first part of hold");
    wdogExpire = 1'b1;
    @(negedge clk);
    wdogExpire = 1'b0;
    checkOut("R7 still asserted", 1'b1);
    waitRelease(1, "R7 restarted hold");

    // R3: power fail while released and idle
    runTicks(5, 1'b0, "R9 idle low");
    #1 pwrGood = 1'b0;
    #1;
    checkOut("R3 second fail", 1'b1);
    @(negedge clk);
    pwrGood = 1'b1;
    waitRelease(1, "R4 short fail hold");

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule